// File: doc/BRIEF.md
# Music Keyboard Host Slot Interface

This block sits in a host expansion slot and connects the host's 8-bit bus to an external music keyboard. The block decodes an eight-byte I/O window. It answers only while the host asserts its device-select strobe and the keyboard asserts its presence line. Four offsets in that window do something, and the other four do nothing.

Offset 4 writes a byte that drives the keyboard's data port. Offset 5 reads the byte captured from the keyboard's input port. Offset 6 reads back the byte currently on the keyboard port. Offset 3 clocks a one-bit handshake flag and, on a read, returns an inverted status byte.

Every host access takes one clock cycle. The host bus has no back-pressure and no wait states. A read places its byte on the data-out bus with the output enable high during that cycle. A write takes effect on the rising edge that ends the cycle.

Top module: `kbd_slot_if`

## Requirements
- R1: An access is qualified only when `dev_sel` and `kbd_present` are both high in the same cycle. With `kbd_present` low, no register changes and `host_doe` stays low.
- R2: Accesses to offsets 0, 1, 2 and 7 leave the port register and the flag unchanged and never raise `host_doe`.
- R3: A qualified write (`rd`=0) to offset 4 loads `host_din` into the port register at that clock edge. `kbd_out` then holds this value until the next such write. Reset clears it to 0x00.
- R4: A qualified read (`rd`=1) at offset 5 returns the value `kbd_in` had at the previous rising clock edge.
- R5: `host_doe` is high only during qualified reads at offsets 3, 5 and 6. Whenever it is low, `host_dout` is 0x00.
- R6: A qualified read at offset 6 returns the current `kbd_out` value.
- R7: A qualified access at offset 3, read or write, sets the handshake flag at the end of that cycle. A status read in the same cycle still shows the flag's earlier value.
- R8: The status byte read at offset 3 has bit 0 equal to the inverse of the flag and bits 7..2 equal to 0. After reset, with the jumper open, it reads 0x01.
- R9: The flag is cleared by reset or by a cycle with `irq_n` low. The clear takes priority over a set in the same cycle.
- R10: Status bit 1 reads 1 while `test_jmp_n` is low (jumper fitted) and 0 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 1 | Host device-select strobe, active high |
| addr | input | 3 | Low address bits selecting the offset |
| rd | input | 1 | 1 = read, 0 = write |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_doe | output | 1 | Read data output enable |
| irq_n | input | 1 | Host interrupt line, active low, clears the flag |
| kbd_out | output | 8 | Keyboard data port |
| kbd_in | input | 8 | Keyboard input port |
| kbd_present | input | 1 | Keyboard presence line, active high |
| test_jmp_n | input | 1 | Test jumper line, low when fitted |

## Verification
The bench builds the block with its default parameters: an 8-bit data width and offsets 3, 4, 5 and 6 for the flag, port, capture and loopback functions. With these values every offset in the window can be reached. The bench uses that to check the four dead offsets, and it checks that an access with the keyboard absent is ignored. It also runs the sequence in which a status read returns the old flag value, the clear by `irq_n` and by reset, and the jumper bit on top of the four constant status bits.

// File: rtl/kbd_slot_pkg.sv
package kbd_slot_pkg;
  typedef struct packed {
    logic flag_hit;  // any qualified access at the flag offset
    logic stat_rd;   // qualified read at the flag offset
    logic port_wr;   // qualified write at the port offset
    logic cap_rd;    // qualified read at the capture offset
    logic loop_rd;   // qualified read at the loopback offset
  } kbd_sel_t;
endpackage

// File: rtl/kbd_slot_decode.sv
module kbd_slot_decode
  import kbd_slot_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int OFS_FLAG = 3,
  parameter int OFS_PORT = 4,
  parameter int OFS_CAP  = 5,
  parameter int OFS_LOOP = 6
) (
  input  logic              dev_sel,
  input  logic              kbd_present,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  output kbd_sel_t          sel
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG);
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(OFS_PORT);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(OFS_CAP);
  localparam logic [ADDR_W-1:0] A_LOOP = ADDR_W'(OFS_LOOP);

  logic hit;
  // third enable is permanently true, so only two terms remain
  assign hit = dev_sel & kbd_present;

  always_comb begin
    sel          = '0;
    sel.flag_hit = hit && (addr == A_FLAG);
    sel.stat_rd  = hit && rd && (addr == A_FLAG);
    sel.port_wr  = hit && !rd && (addr == A_PORT);
    sel.cap_rd   = hit && rd && (addr == A_CAP);
    sel.loop_rd  = hit && rd && (addr == A_LOOP);
  end
endmodule

// File: rtl/kbd_slot_regs.sv
module kbd_slot_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_wr,
  input  logic [DATA_W-1:0] host_din,
  input  logic [DATA_W-1:0] kbd_in,
  output logic [DATA_W-1:0] port_q,
  output logic [DATA_W-1:0] cap_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      cap_q  <= '0;
    end else begin
      cap_q <= kbd_in;
      if (port_wr) port_q <= host_din;
    end
  end
endmodule

// File: rtl/kbd_slot_flag.sv
module kbd_slot_flag #(
  parameter int DATA_W = 8,
  parameter int TIED_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              irq_n,
  input  logic              test_jmp_n,
  output logic              flag_q,
  output logic [DATA_W-1:0] status
);
  localparam int PAD_W = DATA_W - 2 - TIED_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (!irq_n) flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
  end

  // inverting buffer: tied-high inputs read as zero
  logic [TIED_W-1:0] tied_hi;
  assign tied_hi = '1;

  generate
    if (PAD_W > 0) begin : g_pad
      assign status = {{PAD_W{1'b0}}, ~tied_hi, ~test_jmp_n, ~flag_q};
    end else begin : g_nopad
      assign status = {~tied_hi, ~test_jmp_n, ~flag_q};
    end
  endgenerate
endmodule

// File: rtl/kbd_slot_if.sv
module kbd_slot_if
  import kbd_slot_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int OFS_FLAG = 3,
  parameter int OFS_PORT = 4,
  parameter int OFS_CAP  = 5,
  parameter int OFS_LOOP = 6,
  parameter int TIED_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_doe,
  input  logic              irq_n,
  output logic [DATA_W-1:0] kbd_out,
  input  logic [DATA_W-1:0] kbd_in,
  input  logic              kbd_present,
  input  logic              test_jmp_n
);
  kbd_sel_t          sel;
  logic [DATA_W-1:0] port_q, cap_q, status;
  logic              hs_flag;

  kbd_slot_decode #(
    .ADDR_W(ADDR_W), .OFS_FLAG(OFS_FLAG), .OFS_PORT(OFS_PORT),
    .OFS_CAP(OFS_CAP), .OFS_LOOP(OFS_LOOP)
  ) u_dec (
    .dev_sel(dev_sel), .kbd_present(kbd_present), .addr(addr), .rd(rd), .sel(sel)
  );

  kbd_slot_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .port_wr(sel.port_wr), .host_din(host_din),
    .kbd_in(kbd_in), .port_q(port_q), .cap_q(cap_q)
  );

  kbd_slot_flag #(.DATA_W(DATA_W), .TIED_W(TIED_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(sel.flag_hit), .irq_n(irq_n),
    .test_jmp_n(test_jmp_n), .flag_q(hs_flag), .status(status)
  );

  assign kbd_out = port_q;

  always_comb begin
    host_dout = '0;
    host_doe  = 1'b0;
    if (sel.stat_rd) begin
      host_dout = status;
      host_doe  = 1'b1;
    end else if (sel.cap_rd) begin
      host_dout = cap_q;
      host_doe  = 1'b1;
    end else if (sel.loop_rd) begin
      host_dout = port_q;
      host_doe  = 1'b1;
    end
  end
endmodule

// File: rtl/kbd_slot_if_chk.sv
module kbd_slot_if_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_sel,
  input logic [ADDR_W-1:0] addr,
  input logic              rd,
  input logic [DATA_W-1:0] host_din,
  input logic [DATA_W-1:0] host_dout,
  input logic              host_doe,
  input logic              irq_n,
  input logic [DATA_W-1:0] kbd_out,
  input logic              kbd_present,
  input logic              hs_flag
);
  logic wr4;
  assign wr4 = dev_sel && kbd_present && !rd && (addr == ADDR_W'(4));

  // R1
  doe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_doe |-> (dev_sel && kbd_present && rd));

  // R5
  dout_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_doe |-> (host_dout == '0));

  // R3
  port_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr4 |=> (kbd_out == $past(host_din)));

  // R3
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr4 |=> $stable(kbd_out));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |=> !hs_flag);

  // R8
  status_flag_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_doe && addr == ADDR_W'(3)) |-> (host_dout[0] == !hs_flag));
endmodule

bind kbd_slot_if kbd_slot_if_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .addr(addr), .rd(rd),
  .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
  .irq_n(irq_n), .kbd_out(kbd_out), .kbd_present(kbd_present), .hs_flag(hs_flag)
);

// File: tb/kbd_slot_if_test.sv
module kbd_slot_if_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dev_sel = 1'b0;
  logic [2:0] addr = '0;
  logic       rd = 1'b0;
  logic [7:0] host_din = '0;
  logic [7:0] host_dout;
  logic       host_doe;
  logic       irq_n = 1'b1;
  logic [7:0] kbd_out;
  logic [7:0] kbd_in = '0;
  logic       kbd_present = 1'b1;
  logic       test_jmp_n = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  kbd_slot_if uut (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .addr(addr), .rd(rd),
    .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
    .irq_n(irq_n), .kbd_out(kbd_out), .kbd_in(kbd_in),
    .kbd_present(kbd_present), .test_jmp_n(test_jmp_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one-cycle access: drive at negedge, sample before the rising edge
  task automatic acc(input logic [2:0] a, input logic r, input logic [7:0] d,
                     output logic [7:0] q, output logic oe);
    @(negedge clk);
    dev_sel = 1'b1; addr = a; rd = r; host_din = d;
    #2;
    q = host_dout; oe = host_doe;
    @(posedge clk);
    #1;
    dev_sel = 1'b0; rd = 1'b0; host_din = '0;
  endtask

  task automatic clear_flag_irq();
    @(negedge clk); irq_n = 1'b0;
    @(negedge clk); irq_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] q; logic oe;
    #1;
    chk("R3 reset port", kbd_out, 8'h00);
    chk("R5 idle doe", {7'b0, host_doe}, 8'h00);
    acc(3'd3, 1'b1, 8'h00, q, oe);
    chk("R8 reset status", q, 8'h01);
    chk("R5 status doe", {7'b0, oe}, 8'h01);
    acc(3'd3, 1'b1, 8'h00, q, oe);
    chk("R7 flag set by read", q, 8'h00);
  endtask

  task automatic t_flag_clear();
    logic [7:0] q; logic oe;
    clear_flag_irq();
    acc(3'd3, 1'b0, 8'hFF, q, oe);
    chk("R5 write no doe", {7'b0, oe}, 8'h00);
    acc(3'd3, 1'b1, 8'h00, q, oe);
    chk("R7 flag set by write", q, 8'h00);
    clear_flag_irq();
    acc(3'd3, 1'b1, 8'h00, q, oe);
    chk("R9 irq clears flag", q, 8'h01);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    acc(3'd3, 1'b1, 8'h00, q, oe);
    chk("R9 reset clears flag", q, 8'h01);
    // clear and set in the same cycle: clear wins
    @(negedge clk);
    irq_n = 1'b0; dev_sel = 1'b1; addr = 3'd3; rd = 1'b0;
    @(negedge clk);
    irq_n = 1'b1; dev_sel = 1'b0;
    acc(3'd3, 1'b1, 8'h00, q, oe);
    chk("R9 clear beats set", q, 8'h01);
  endtask

  task automatic t_absent();
    logic [7:0] q; logic oe;
    clear_flag_irq();
    kbd_present = 1'b0;
    acc(3'd4, 1'b0, 8'hA5, q, oe);
    chk("R1 absent write ignored", kbd_out, 8'h00);
    acc(3'd5, 1'b1, 8'h00, q, oe);
    chk("R1 absent read no doe", {7'b0, oe}, 8'h00);
    acc(3'd3, 1'b0, 8'h00, q, oe);
    kbd_present = 1'b1;
    acc(3'd3, 1'b1, 8'h00, q, oe);
    chk("R1 absent flag untouched", q, 8'h01);
  endtask

  task automatic t_unused();
    logic [7:0] q; logic oe;
    logic [2:0] dead [4] = '{3'd0, 3'd1, 3'd2, 3'd7};
    clear_flag_irq();
    for (int i = 0; i < 4; i++) begin
      acc(dead[i], 1'b0, 8'hFF, q, oe);
      chk("R2 dead write port", kbd_out, 8'h00);
      acc(dead[i], 1'b1, 8'h00, q, oe);
      chk("R2 dead read doe", {7'b0, oe}, 8'h00);
    end
    acc(3'd3, 1'b1, 8'h00, q, oe);
    chk("R2 dead flag untouched", q, 8'h01);
  endtask

  task automatic t_port();
    logic [7:0] q; logic oe;
    acc(3'd4, 1'b0, 8'h3C, q, oe);
    chk("R3 port load", kbd_out, 8'h3C);
    acc(3'd6, 1'b1, 8'h00, q, oe);
    chk("R6 loopback", q, 8'h3C);
    acc(3'd4, 1'b1, 8'h77, q, oe);
    chk("R3 read at port no load", kbd_out, 8'h3C);
    acc(3'd4, 1'b0, 8'hC3, q, oe);
    acc(3'd6, 1'b1, 8'h00, q, oe);
    chk("R6 loopback second", q, 8'hC3);
  endtask

  task automatic t_capture();
    logic [7:0] q; logic oe;
    kbd_in = 8'h96;
    repeat (2) @(negedge clk);
    acc(3'd5, 1'b1, 8'h00, q, oe);
    chk("R4 capture", q, 8'h96);
    kbd_in = 8'h5A;
    repeat (2) @(negedge clk);
    acc(3'd5, 1'b1, 8'h00, q, oe);
    chk("R4 capture second", q, 8'h5A);
    chk("R5 capture doe", {7'b0, oe}, 8'h01);
  endtask

  task automatic t_jumper();
    logic [7:0] q; logic oe;
    clear_flag_irq();
    test_jmp_n = 1'b0;
    acc(3'd3, 1'b1, 8'h00, q, oe);
    chk("R10 jumper fitted", q, 8'h03);
    test_jmp_n = 1'b1;
    acc(3'd3, 1'b1, 8'h00, q, oe);
    chk("R10 jumper open", q, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_flag_clear();
    t_absent();
    t_unused();
    t_port();
    t_capture();
    t_jumper();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule